// File: doc/BRIEF.md
# Addressable RGB LED Waveform Encoder

This block drives the single data wire of a chain of smart RGB LEDs. It takes 24-bit pixel words from a ready/valid stream, normally fed by a FIFO, and turns each bit into a high pulse followed by a low pulse. The length of each pulse, counted in module-clock cycles, comes from four separate timing inputs. A one bit and a zero bit each have their own high time and low time. Within every pixel the three colour bytes can be put on the wire in any of six orders.

A transfer begins with a one-cycle `start` while the block is idle. At that moment the block captures the frame length, the colour order and all timing inputs. It then sends exactly the requested number of pixels and holds the line low for the programmed latch interval. Finally it emits a one-cycle `done` pulse. If the next pixel is not ready when it is due, the line simply stays low until it arrives.

The package also provides the nominal pulse lengths in nanoseconds and a conversion helper, so an integrator can derive tie-off values for a given module clock. The nominal lengths are: zero-high 336 ns, zero-low 840 ns, one-high 882 ns, one-low 294 ns, latch 300 µs.

Top module: `ledstrip_encoder`

## Requirements
- R1: A pixel word holds red in bits 23:16, green in 15:8 and blue in 7:0. `color_order` codes 0,1,2,3,4,5 put the bytes on the wire as R-G-B, R-B-G, G-R-B, G-B-R, B-R-G, B-G-R. Each byte is sent most significant bit first.
- R2: `color_order` codes 6 and 7 behave like code 0 (R-G-B).
- R3: A one bit is `t1h_cyc` cycles high then `t1l_cyc` cycles low. A zero bit is `t0h_cyc` cycles high then `t0l_cyc` cycles low. The field widths are 6, 5, 5 and 6 bits, and a field of 0 acts as 1 cycle.
- R4: After the low phase of the last bit, `dout` stays low for `treset_cyc` cycles (13 bits, 0 acts as 1). `done` is then high for exactly one cycle, and in that same cycle `busy` has fallen.
- R5: A transfer accepts exactly `frame_len` pixels (13 bits). A further pixel that is offered is not taken. With `frame_len` 0, the transfer consists of the latch interval alone.
- R6: While the next pixel is not available, `dout` stays low and the block waits. No pixel is dropped or repeated.
- R7: After reset and whenever no transfer is active, `dout`, `busy`, `pix_ready` and `done` are low.
- R8: The frame length, colour order and timing inputs are captured at `start`. Changes to them during a transfer, and `start` pulses during a transfer, have no effect on it.
- R9: The first high phase of a pixel begins in the cycle after that pixel is accepted. A pixel that is already valid when the previous one ends is taken without adding any cycle to the previous bit's low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a transfer (used only when idle) |
| frame_len | input | 13 | Number of pixels in the transfer |
| color_order | input | 3 | Byte order on the wire |
| t1h_cyc | input | 6 | High cycles of a one bit |
| t1l_cyc | input | 5 | Low cycles of a one bit |
| t0h_cyc | input | 5 | High cycles of a zero bit |
| t0l_cyc | input | 6 | Low cycles of a zero bit |
| treset_cyc | input | 13 | Latch low interval in cycles |
| pix_data | input | 24 | Pixel word, red 23:16, green 15:8, blue 7:0 |
| pix_valid | input | 1 | Pixel word is valid |
| pix_ready | output | 1 | Block accepts the pixel this cycle |
| dout | output | 1 | Serial line to the LED chain |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle transfer-finished pulse |

## Verification
The assertions watch, on every cycle, for the following: the line and ready driven while idle, a high phase longer than the widest field allows, a pixel accepted beyond the captured frame length, the line high while waiting for a pixel, and a `done` that is wider than one cycle or not at the end of a transfer. Only the bench scenarios can show that the waveform is correct cycle for cycle. That covers the byte orders, the exact pulse and latch lengths, zero-width fields, the gapless hand-off between pixels, correct data under random stalls, and indifference to configuration changes made mid-transfer.

// File: rtl/ledenc_pkg.sv
// Shared types and constants for the LED waveform encoder.
// Assumes the integrator converts nominal nanosecond values to cycles.
package ledenc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_HIGH  = 3'd2,
        ST_LOW   = 3'd3,
        ST_LATCH = 3'd4
    } enc_state_t;

    // Nominal power-up pulse lengths in nanoseconds
    localparam int NOM_T0H_NS   = 336;
    localparam int NOM_T0L_NS   = 840;
    localparam int NOM_T1H_NS   = 882;
    localparam int NOM_T1L_NS   = 294;
    localparam int NOM_RESET_NS = 300000;

    // Cycle count for a duration, truncated like a tie-off computation
    function automatic int ns_to_cycles(input int ns, input int period_ns);
        return ns / period_ns;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ledenc_reorder.sv
// Colour byte reorder: maps an R/G/B pixel word to wire order.
// Assumes PIX_W is three equal bytes; unknown codes fall back to R-G-B.
module ledenc_reorder #(
    parameter int PIX_W = 24
) (
    input  logic [2:0]       order,
    input  logic [PIX_W-1:0] pix_in,
    output logic [PIX_W-1:0] wire_word
);
    localparam int CW = PIX_W / 3;

    logic [CW-1:0] r, g, b;
    assign r = pix_in[3*CW-1:2*CW];
    assign g = pix_in[2*CW-1:CW];
    assign b = pix_in[CW-1:0];

    // Select the byte sequence for the requested order
    always_comb begin
        case (order)
            3'd1:    wire_word = {r, b, g};
            3'd2:    wire_word = {g, r, b};
            3'd3:    wire_word = {g, b, r};
            3'd4:    wire_word = {b, r, g};
            3'd5:    wire_word = {b, g, r};
            default: wire_word = {r, g, b};
        endcase
    end
endmodule

// File: rtl/ledenc_shifter.sv
// Bit shifter: holds the pixel in wire order, MSB is the current bit.
// Assumes load and shift are never asserted together.
module ledenc_shifter #(
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PIX_W-1:0] load_word,
    input  logic             shift,
    output logic             cur_bit,
    output logic             nxt_bit,
    output logic             last_bit
);
    localparam int IDX_W = $clog2(PIX_W);

    logic [PIX_W-1:0] word_q;
    logic [IDX_W-1:0] idx_q;

    // Load a new pixel or advance one bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            idx_q  <= '0;
        end else if (load) begin
            word_q <= load_word;
            idx_q  <= IDX_W'(PIX_W - 1);
        end else if (shift) begin
            word_q <= {word_q[PIX_W-2:0], 1'b0};
            idx_q  <= idx_q - 1'b1;
        end
    end

    assign cur_bit  = word_q[PIX_W-1];
    assign nxt_bit  = word_q[PIX_W-2];
    assign last_bit = (idx_q == '0);
endmodule

// File: rtl/ledenc_timer.sv
// Phase timer: counts a loaded cycle budget down; a budget of 0 lasts 1 cycle.
// Assumes load occurs on the cycle a phase is entered.
module ledenc_timer #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    assign expire = (cnt_q <= CNT_W'(1));

    // Reload on phase entry, otherwise count down to the final cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (!expire)
            cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/ledstrip_encoder.sv
// LED waveform encoder top: takes pixels over ready/valid and drives the
// one-wire pulse train, then the latch interval and a finish pulse.
// Assumes config inputs are meaningful on the start cycle only.
module ledstrip_encoder
    import ledenc_pkg::*;
#(
    parameter int PIX_W = 24,
    parameter int LEN_W = 13,
    parameter int T1H_W = 6,
    parameter int T1L_W = 5,
    parameter int T0H_W = 5,
    parameter int T0L_W = 6,
    parameter int TR_W  = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] frame_len,
    input  logic [2:0]       color_order,
    input  logic [T1H_W-1:0] t1h_cyc,
    input  logic [T1L_W-1:0] t1l_cyc,
    input  logic [T0H_W-1:0] t0h_cyc,
    input  logic [T0L_W-1:0] t0l_cyc,
    input  logic [TR_W-1:0]  treset_cyc,
    input  logic [PIX_W-1:0] pix_data,
    input  logic             pix_valid,
    output logic             pix_ready,
    output logic             dout,
    output logic             busy,
    output logic             done
);
    localparam int CNT_W = max2(max2(TR_W, T1H_W), max2(T0L_W, max2(T1L_W, T0H_W)));

    enc_state_t state_q, state_d;

    logic [2:0]       ord_q;
    logic [T1H_W-1:0] t1h_q;
    logic [T1L_W-1:0] t1l_q;
    logic [T0H_W-1:0] t0h_q;
    logic [T0L_W-1:0] t0l_q;
    logic [TR_W-1:0]  tr_q;
    logic [LEN_W-1:0] remain_q;
    logic             done_q;

    logic [PIX_W-1:0] wire_word;
    logic             cur_bit, nxt_bit, last_bit, expire;
    logic             tmr_load, take, more_px, bit_end, do_shift;
    logic [CNT_W-1:0] tmr_val, th_new, th_nxt, tl_cur;

    ledenc_reorder #(.PIX_W(PIX_W)) u_reorder (
        .order     (ord_q),
        .pix_in    (pix_data),
        .wire_word (wire_word)
    );

    ledenc_shifter #(.PIX_W(PIX_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take),
        .load_word (wire_word),
        .shift     (do_shift),
        .cur_bit   (cur_bit),
        .nxt_bit   (nxt_bit),
        .last_bit  (last_bit)
    );

    ledenc_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (expire)
    );

    // Phase budgets for the incoming pixel, the next bit and the current bit
    assign th_new = wire_word[PIX_W-1] ? CNT_W'(t1h_q) : CNT_W'(t0h_q);
    assign th_nxt = nxt_bit ? CNT_W'(t1h_q) : CNT_W'(t0h_q);
    assign tl_cur = cur_bit ? CNT_W'(t1l_q) : CNT_W'(t0l_q);

    assign more_px   = (remain_q != LEN_W'(1));
    assign bit_end   = (state_q == ST_LOW) && expire && last_bit;
    assign do_shift  = (state_q == ST_LOW) && expire && !last_bit;
    assign pix_ready = (state_q == ST_FETCH) || (bit_end && more_px);
    assign take      = pix_valid && pix_ready;

    // Next phase and timer reload
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (frame_len == '0) begin
                        state_d  = ST_LATCH;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(treset_cyc);
                    end else begin
                        state_d = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (take) begin
                    state_d  = ST_HIGH;
                    tmr_load = 1'b1;
                    tmr_val  = th_new;
                end
            end
            ST_HIGH: begin
                if (expire) begin
                    state_d  = ST_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = tl_cur;
                end
            end
            ST_LOW: begin
                if (expire) begin
                    if (!last_bit) begin
                        state_d  = ST_HIGH;
                        tmr_load = 1'b1;
                        tmr_val  = th_nxt;
                    end else if (!more_px) begin
                        state_d  = ST_LATCH;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(tr_q);
                    end else if (take) begin
                        state_d  = ST_HIGH;
                        tmr_load = 1'b1;
                        tmr_val  = th_new;
                    end else begin
                        state_d = ST_FETCH;
                    end
                end
            end
            ST_LATCH: begin
                if (expire) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, captured configuration, pixel countdown and finish pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            ord_q    <= '0;
            t1h_q    <= '0;
            t1l_q    <= '0;
            t0h_q    <= '0;
            t0l_q    <= '0;
            tr_q     <= '0;
            remain_q <= '0;
            done_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_LATCH) && expire;
            if (state_q == ST_IDLE && start) begin
                ord_q    <= color_order;
                t1h_q    <= t1h_cyc;
                t1l_q    <= t1l_cyc;
                t0h_q    <= t0h_cyc;
                t0l_q    <= t0l_cyc;
                tr_q     <= treset_cyc;
                remain_q <= frame_len;
            end else if (bit_end && more_px) begin
                remain_q <= remain_q - 1'b1;
            end
        end
    end

    assign dout = (state_q == ST_HIGH);
    assign busy = (state_q != ST_IDLE);
    assign done = done_q;
endmodule

// File: rtl/ledenc_checker.sv
// Protocol checker for the LED waveform encoder, bound to the top module.
// Assumes the top's port names; tracks accepted pixels and high-run length.
module ledenc_checker #(
    parameter int LEN_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [LEN_W-1:0] frame_len,
    input logic             pix_valid,
    input logic             pix_ready,
    input logic             dout,
    input logic             busy,
    input logic             done
);
    logic [LEN_W-1:0] len_q;
    logic [LEN_W:0]   acc_q;
    logic [6:0]       hi_run_q;

    // Capture the frame length and count accepted pixels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
            acc_q <= '0;
        end else if (start && !busy) begin
            len_q <= frame_len;
            acc_q <= '0;
        end else if (pix_valid && pix_ready) begin
            acc_q <= acc_q + 1'b1;
        end
    end

    // Length of the current high run on the line
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_run_q <= '0;
        else if (dout)
            hi_run_q <= (hi_run_q == 7'd127) ? hi_run_q : hi_run_q + 1'b1;
        else
            hi_run_q <= '0;
    end

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!dout && !pix_ready)); // R7

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4

    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R4

    AST_NO_EXTRA_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_ready) |-> (acc_q < {1'b0, len_q})); // R5

    AST_HIGH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        dout |-> (hi_run_q < 7'd63)); // R3

    AST_STALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_ready && !pix_valid) |-> !dout); // R6
endmodule

bind ledstrip_encoder ledenc_checker #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .frame_len (frame_len),
    .pix_valid (pix_valid),
    .pix_ready (pix_ready),
    .dout      (dout),
    .busy      (busy),
    .done      (done)
);

// File: tb/test_ledstrip_encoder.sv
// Bench for the LED waveform encoder: directed corners plus seeded random
// frames, each compared against a waveform built by bench functions.
module test_ledstrip_encoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [12:0] frame_len = '0;
    logic [2:0]  color_order = '0;
    logic [5:0]  t1h_cyc = '0;
    logic [4:0]  t1l_cyc = '0;
    logic [4:0]  t0h_cyc = '0;
    logic [5:0]  t0l_cyc = '0;
    logic [12:0] treset_cyc = '0;
    logic [23:0] pix_data = '0;
    logic        pix_valid = 1'b0;
    logic        pix_ready, dout, busy, done;

    int n_tests = 0;
    int n_fail  = 0;

    bit          cap  [20000];
    bit          expw [20000];
    logic [23:0] pix  [9];

    always #5 clk = ~clk;

    ledstrip_encoder i_ledstrip_encoder (
        .clk(clk), .rst_n(rst_n), .start(start), .frame_len(frame_len),
        .color_order(color_order), .t1h_cyc(t1h_cyc), .t1l_cyc(t1l_cyc),
        .t0h_cyc(t0h_cyc), .t0l_cyc(t0l_cyc), .treset_cyc(treset_cyc),
        .pix_data(pix_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
        .dout(dout), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic logic [23:0] ref_order(input int o, input logic [23:0] p);
        logic [7:0] r, g, b;
        r = p[23:16]; g = p[15:8]; b = p[7:0];
        case (o)
            1: return {r, b, g};
            2: return {g, r, b};
            3: return {g, b, r};
            4: return {b, r, g};
            5: return {b, g, r};
            default: return {r, g, b};
        endcase
    endfunction

    function automatic int eff(input int x);
        return (x == 0) ? 1 : x;
    endfunction

    // One transfer: drive, capture the line while busy, then compare
    task automatic run_frame(input int n, input int ord, input int a1h, input int a1l,
                             input int a0h, input int a0l, input int atr,
                             input bit stall, input bit perturb, input string req);
        int ne, ncap, idx, acc, idle_hi, bad, first_bad, nb, i, h;
        bit took, got_done, bitv, expb;
        logic [23:0] w;
        for (int p = 0; p < 9; p++) pix[p] = 24'($urandom);
        ne = 0;
        if (n > 0) expw[ne++] = 1'b0;
        for (int p = 0; p < n; p++) begin
            w = ref_order(ord, pix[p]);
            for (int k = 23; k >= 0; k--) begin
                for (int c = 0; c < eff(w[k] ? a1h : a0h); c++) expw[ne++] = 1'b1;
                for (int c = 0; c < eff(w[k] ? a1l : a0l); c++) expw[ne++] = 1'b0;
            end
        end
        for (int c = 0; c < eff(atr); c++) expw[ne++] = 1'b0;

        frame_len = 13'(n); color_order = 3'(ord);
        t1h_cyc = 6'(a1h); t1l_cyc = 5'(a1l); t0h_cyc = 5'(a0h); t0l_cyc = 6'(a0l);
        treset_cyc = 13'(atr);
        idx = 0; took = 0; ncap = 0; acc = 0; idle_hi = 0; got_done = 0;
        for (int k = 0; k < 40000 && !got_done; k++) begin
            @(negedge clk);
            start = (k == 0) || (perturb && (k == 5 || k == 40));
            if (perturb && k == 3) begin
                color_order = 3'(ord + 1);
                t1h_cyc = 6'(a1h + 3); t1l_cyc = 5'(a1l + 2);
                t0h_cyc = 5'(a0h + 1); t0l_cyc = 6'(a0l + 4);
                treset_cyc = 13'(atr + 7); frame_len = 13'(n + 2);
            end
            if (took) idx++;
            pix_valid = (idx <= n) && (!stall || ($urandom_range(0, 2) != 0));
            pix_data  = (idx < 9) ? pix[idx] : 24'd0;
            took = pix_valid && pix_ready;
            if (took) acc++;
            if (busy) begin
                if (ncap < 20000) cap[ncap] = dout;
                ncap++;
            end else if (dout) idle_hi++;
            if (done) got_done = 1;
        end
        start = 1'b0; pix_valid = 1'b0;
        chk(got_done, req, "transfer finished", int'(got_done), 1);
        chk(acc == n, "R5", "pixels accepted", acc, n);
        chk(idle_hi == 0, "R7", "line high while idle", idle_hi, 0);
        @(negedge clk);
        chk(!done && !busy, "R4", "finish pulse width", int'(done), 0);
        if (!stall) begin
            chk(ncap == ne, req, "busy cycles", ncap, ne);
            bad = 0; first_bad = -1;
            for (int c = 0; c < ne && c < ncap && c < 20000; c++)
                if (cap[c] != expw[c]) begin
                    bad++;
                    if (first_bad < 0) first_bad = c;
                end
            chk(bad == 0, req, "waveform mismatch at cycle", first_bad, -1);
        end else begin
            i = 0; nb = 0; bad = 0;
            while (i < ncap && i < 20000) begin
                if (cap[i]) begin
                    h = 0;
                    while (i < ncap && i < 20000 && cap[i]) begin h++; i++; end
                    if (h != eff(a1h) && h != eff(a0h)) bad++;
                    bitv = (h == eff(a1h));
                    if (nb < n * 24) begin
                        w = ref_order(ord, pix[nb / 24]);
                        expb = w[23 - (nb % 24)];
                        if (bitv != expb) bad++;
                    end
                    nb++;
                end else i++;
            end
            chk(nb == n * 24, req, "bits under stall", nb, n * 24);
            chk(bad == 0, req, "bit errors under stall", bad, 0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #1900000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Main sequence
    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: reset state
        chk(!dout && !busy && !done && !pix_ready, "R7", "reset outputs",
            int'({dout, busy, done, pix_ready}), 0);

        // R1: the six byte orders
        for (int o = 0; o < 6; o++) run_frame(2, o, 3, 2, 1, 4, 5, 0, 0, "R1");
        // R2: unused order codes fall back to R-G-B
        run_frame(2, 6, 3, 2, 1, 4, 5, 0, 0, "R2");
        run_frame(1, 7, 2, 3, 4, 1, 2, 0, 0, "R2");
        // R3: widest fields and zero-width fields
        run_frame(1, 2, 63, 31, 31, 63, 3, 0, 0, "R3");
        run_frame(2, 0, 4, 0, 0, 3, 1, 0, 0, "R3");
        // R4: shortest and longest latch interval
        run_frame(1, 3, 2, 2, 1, 1, 0, 0, 0, "R4");
        run_frame(1, 4, 2, 2, 1, 1, 8191, 0, 0, "R4");
        // R5: empty frame sends only the latch interval
        run_frame(0, 0, 2, 2, 1, 1, 9, 0, 0, "R5");
        // R6: random stalls on the pixel stream
        run_frame(3, 2, 5, 3, 2, 4, 4, 1, 0, "R6");
        run_frame(4, 5, 5, 1, 2, 2, 6, 1, 0, "R6");
        // R8: config changes and start pulses mid-transfer
        run_frame(2, 1, 3, 2, 1, 4, 5, 0, 1, "R8");
        // R9: random frames with a continuous stream, exact waveform
        for (int t = 0; t < 20; t++)
            run_frame($urandom_range(1, 3), $urandom_range(0, 7),
                      $urandom_range(0, 12), $urandom_range(0, 12),
                      $urandom_range(0, 12), $urandom_range(0, 12),
                      $urandom_range(0, 40), 0, 0, "R9");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule